// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Saturation Flag

This unit performs 32-bit saturating arithmetic for a datapath. A caller presents an operation code, two operands and a 5-bit width field together with a valid strobe. On that clock edge the unit registers the result and may set a sticky saturation flag. The flag stays set until a dedicated clear input is raised, so one flag can gather saturation events across a whole sequence of operations.

The operations are:
- signed add and subtract that clamp on overflow, plus an add that only records overflow;
- signed doubling with fixed thresholds;
- unsigned add and subtract that clamp;
- signed and unsigned clamping of a value to a selectable bit width;
- the same width clamping applied to each 16-bit half of a word on its own, with both halves feeding the one shared flag.

Top module: `sat_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, `result` becomes 0 and `sat_flag` becomes 0.
- R2: Op code 0 (signed clamping add) gives a+b. When a and b share a sign and the sum's sign differs, the result is 0x7FFFFFFF if a is non-negative and 0x80000000 otherwise, and the flag is set.
- R3: Op code 1 (signed clamping subtract) gives a−b. When the signs of a and b differ and the result's sign differs from a, it clamps as in R2 and the flag is set.
- R4: Op code 2 (flagging add) returns the wrapped 32-bit sum a+b unchanged and sets the flag on the same signed overflow condition as R2.
- R5: Op code 3 (doubling) uses only a. If a ≥ 0x40000000 (signed) it gives 0x7FFFFFFF and sets the flag. If a ≤ 0xC0000000 (signed) it gives 0x80000000 and sets the flag. Otherwise it gives a shifted left by one.
- R6: Op code 4 (unsigned add) gives all ones and sets the flag when a+b exceeds 32 bits. Op code 5 (unsigned subtract) gives 0 and sets the flag when b > a. Otherwise both give the plain result.
- R7: Op code 6 (signed width clamp) with width n limits a to the range −2^n to 2^n−1. Out-of-range values go to the nearer bound and set the flag.
- R8: Op code 7 (unsigned width clamp) with width n gives 0 for negative a and 2^n−1 for a above 2^n−1. Either case sets the flag.
- R9: Op codes 8 and 9 apply the R7 and R8 clamps respectively to bits [15:0] and bits [31:16] of a. Each half is treated as a signed 16-bit value and its 16-bit result goes back to the same position. A clamp in either half sets the one shared flag.
- R10: A cycle with `in_valid` low leaves `result` and `sat_flag` unchanged. Op codes 10 to 15 give result 0 and never set the flag.
- R11: The flag is sticky: once set it stays set through later non-saturating operations. `flag_clr` clears it on the next edge and wins over a saturating operation in the same cycle, while `result` still updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand / value to clamp or double |
| opnd_b | input | 32 | Second operand for add and subtract |
| sat_width | input | 5 | Width n for the clamp operations |
| in_valid | input | 1 | Register the operation on this edge |
| flag_clr | input | 1 | Clear the sticky flag |
| result | output | 32 | Registered result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The only state is the result register and the flag register. Any fault in either shows on the ports one cycle after the edge that loaded it. A wrong flag shows at once as a set flag after a clear, or as a flag that drops without a clear. Because the flag is sticky, a missed or spurious set stays visible until the next clear. The bench therefore clears the flag before each checked operation, so each saturation event can be traced to a single operation. The clamp bounds, such as exactly 0xC0000000 for doubling and exactly 2^n−1 for the width clamps, are driven on both sides of each threshold.

// File: rtl/sat_alu_pkg.sv
// Package: shared operation codes for the saturating arithmetic unit.
// Assumes a 4-bit operation select; codes above USAT16 are undefined.
package sat_alu_pkg;
    typedef enum logic [3:0] {
        OP_SADD   = 4'd0,
        OP_SSUB   = 4'd1,
        OP_ADDF   = 4'd2,
        OP_DBL    = 4'd3,
        OP_UADD   = 4'd4,
        OP_USUB   = 4'd5,
        OP_SSAT   = 4'd6,
        OP_USAT   = 4'd7,
        OP_SSAT16 = 4'd8,
        OP_USAT16 = 4'd9
    } sat_op_e;
endpackage

// File: rtl/sat_addsub.sv
// Module: add/subtract with signed or unsigned clamping.
// Does: one adder serves add and subtract; detects signed overflow or
// unsigned carry/borrow and optionally clamps. Assumes W >= 2.
module sat_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_sub,
    input  logic         is_uns,
    input  logic         clamp_en,
    output logic [W-1:0] res,
    output logic         sat
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W:0]   full;
    logic         s_ovf;
    logic         u_ovf;

    // Shared adder: subtract is a + ~b + 1.
    always_comb begin
        b_eff = is_sub ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
    end

    // Overflow detection for both signednesses.
    always_comb begin
        s_ovf = (a[MSB] == b_eff[MSB]) && (full[MSB] != a[MSB]);
        u_ovf = is_sub ? ~full[W] : full[W];
    end

    // Result selection with clamping.
    always_comb begin
        res = full[W-1:0];
        sat = 1'b0;
        if (is_uns) begin
            sat = u_ovf;
            if (u_ovf) res = is_sub ? '0 : '1;
        end else begin
            sat = s_ovf;
            if (s_ovf && clamp_en) res = a[MSB] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/sat_clamp.sv
// Module: clamp a signed W-bit value to an n-bit signed or unsigned range.
// Does: signed mode limits to [-2^n, 2^n-1]; unsigned mode to [0, 2^n-1].
// Assumes n may exceed W-1, in which case no signed clamp can occur.
module sat_clamp #(
    parameter int W  = 32,
    parameter int NW = 5
) (
    input  logic [W-1:0]  val,
    input  logic [NW-1:0] n,
    input  logic          is_uns,
    output logic [W-1:0]  res,
    output logic          sat
);
    localparam int MSB = W - 1;

    logic [W-1:0]        mask;
    logic signed [W-1:0] top;

    // Bound mask 2^n-1 and the bits above the range.
    always_comb begin
        mask = ~({W{1'b1}} << n);
        top  = $signed(val) >>> n;
    end

    // Clamp decision per mode.
    always_comb begin
        res = val;
        sat = 1'b0;
        if (is_uns) begin
            if (val[MSB]) begin
                res = '0;
                sat = 1'b1;
            end else if (val > mask) begin
                res = mask;
                sat = 1'b1;
            end
        end else begin
            if (!val[MSB] && (top != '0)) begin
                res = mask;
                sat = 1'b1;
            end else if (val[MSB] && (top != '1)) begin
                res = ~mask;
                sat = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sat_alu.sv
// Module: saturating arithmetic unit with a sticky saturation flag.
// Does: selects one of ten saturating operations, registers the result
// on in_valid, and accumulates saturation events in a flag cleared only
// by flag_clr (clear wins). Assumes DATA_W is even; halves are DATA_W/2.
module sat_alu #(
    parameter int DATA_W = 32,
    parameter int NW     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [NW-1:0]     sat_width,
    input  logic              in_valid,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] result,
    output logic              sat_flag
);
    import sat_alu_pkg::*;

    localparam int HALF_W = DATA_W / 2;
    localparam int LANES  = 2;
    localparam logic signed [DATA_W-1:0] DBL_HI = DATA_W'(1) << (DATA_W - 2);
    localparam logic signed [DATA_W-1:0] DBL_LO = -DBL_HI;

    sat_op_e op;
    assign op = sat_op_e'(op_sel);

    // Adder path controls.
    logic              as_sub, as_uns, as_clamp, as_sat;
    logic [DATA_W-1:0] as_res;

    always_comb begin
        as_sub   = (op == OP_SSUB) || (op == OP_USUB);
        as_uns   = (op == OP_UADD) || (op == OP_USUB);
        as_clamp = (op != OP_ADDF);
    end

    sat_addsub #(.W(DATA_W)) i_addsub (
        .a(opnd_a), .b(opnd_b), .is_sub(as_sub), .is_uns(as_uns),
        .clamp_en(as_clamp), .res(as_res), .sat(as_sat)
    );

    // Full-width clamp path.
    logic              wc_uns, wc_sat;
    logic [DATA_W-1:0] wc_res;
    assign wc_uns = (op == OP_USAT);

    sat_clamp #(.W(DATA_W), .NW(NW)) i_clamp_full (
        .val(opnd_a), .n(sat_width), .is_uns(wc_uns), .res(wc_res), .sat(wc_sat)
    );

    // Per-half clamp path.
    logic              hc_uns;
    logic [DATA_W-1:0] hc_res;
    logic [LANES-1:0]  hc_sat;
    assign hc_uns = (op == OP_USAT16);

    for (genvar h = 0; h < LANES; h++) begin : g_half
        sat_clamp #(.W(HALF_W), .NW(NW)) i_clamp_half (
            .val(opnd_a[h*HALF_W +: HALF_W]), .n(sat_width), .is_uns(hc_uns),
            .res(hc_res[h*HALF_W +: HALF_W]), .sat(hc_sat[h])
        );
    end

    // Doubling with fixed thresholds.
    logic              dbl_sat;
    logic [DATA_W-1:0] dbl_res;
    always_comb begin
        dbl_sat = 1'b1;
        if ($signed(opnd_a) >= DBL_HI)      dbl_res = {1'b0, {(DATA_W-1){1'b1}}};
        else if ($signed(opnd_a) <= DBL_LO) dbl_res = {1'b1, {(DATA_W-1){1'b0}}};
        else begin
            dbl_res = opnd_a << 1;
            dbl_sat = 1'b0;
        end
    end

    // Operation select.
    logic [DATA_W-1:0] nxt_res;
    logic              nxt_sat;
    always_comb begin
        unique case (op)
            OP_SADD, OP_SSUB, OP_ADDF, OP_UADD, OP_USUB: begin
                nxt_res = as_res;  nxt_sat = as_sat;
            end
            OP_DBL: begin
                nxt_res = dbl_res; nxt_sat = dbl_sat;
            end
            OP_SSAT, OP_USAT: begin
                nxt_res = wc_res;  nxt_sat = wc_sat;
            end
            OP_SSAT16, OP_USAT16: begin
                nxt_res = hc_res;  nxt_sat = |hc_sat;
            end
            default: begin
                nxt_res = '0;      nxt_sat = 1'b0;
            end
        endcase
    end

    // Result register: loads on valid.
    always_ff @(posedge clk) begin
        if (!rst_n)        result <= '0;
        else if (in_valid) result <= nxt_res;
    end

    // Sticky flag: clear has priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n)                   sat_flag <= 1'b0;
        else if (flag_clr)            sat_flag <= 1'b0;
        else if (in_valid && nxt_sat) sat_flag <= 1'b1;
    end
endmodule

// File: rtl/sat_alu_chk.sv
// Module: assertion checker for sat_alu, attached by bind.
// Assumes the port semantics of the brief's requirements.
module sat_alu_chk #(
    parameter int DATA_W = 32,
    parameter int NW     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] opnd_a,
    input logic [NW-1:0]     sat_width,
    input logic              in_valid,
    input logic              flag_clr,
    input logic [DATA_W-1:0] result,
    input logic              sat_flag
);
    a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> !sat_flag);

    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !flag_clr) |=> sat_flag);

    a_r10_flag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> ($past(in_valid) && !$past(flag_clr)));

    a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    a_r6_uadd_not_below: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd4) |=> (result >= $past(opnd_a)));

    a_r6_usub_not_above: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd5) |=> (result <= $past(opnd_a)));

    a_r8_usat_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd7) |=> ((result >> $past(sat_width)) == '0));

    a_r5_dbl_even_or_max: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd3) |=> (!result[0] || result == {1'b0, {(DATA_W-1){1'b1}}}));
endmodule

bind sat_alu sat_alu_chk #(.DATA_W(DATA_W), .NW(NW)) i_sat_alu_chk (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
    .sat_width(sat_width), .in_valid(in_valid), .flag_clr(flag_clr),
    .result(result), .sat_flag(sat_flag)
);

// File: tb/test_sat_alu.sv
// Directed bench for sat_alu: one task per scenario, each checking itself.
module test_sat_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [4:0]  sat_width = '0;
    logic        in_valid = 1'b0, flag_clr = 1'b0;
    logic [31:0] result;
    logic        sat_flag;

    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    sat_alu i_sat_alu (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .sat_width(sat_width), .in_valid(in_valid), .flag_clr(flag_clr),
        .result(result), .sat_flag(sat_flag)
    );

    // Reference models built from the requirements; return {flag, value}.
    function automatic logic [32:0] m_signed(logic [31:0] a, logic [31:0] b, bit sub, bit clamp);
        longint s = sub ? longint'($signed(a)) - longint'($signed(b))
                        : longint'($signed(a)) + longint'($signed(b));
        if (s > 64'sd2147483647)  return clamp ? {1'b1, 32'h7FFFFFFF} : {1'b1, s[31:0]};
        if (s < -64'sd2147483648) return clamp ? {1'b1, 32'h80000000} : {1'b1, s[31:0]};
        return {1'b0, s[31:0]};
    endfunction

    function automatic logic [32:0] m_uns(logic [31:0] a, logic [31:0] b, bit sub);
        longint s = sub ? longint'(a) - longint'(b) : longint'(a) + longint'(b);
        if (s > 64'sd4294967295) return {1'b1, 32'hFFFFFFFF};
        if (s < 0)               return {1'b1, 32'h0};
        return {1'b0, s[31:0]};
    endfunction

    function automatic logic [32:0] m_dbl(logic [31:0] a);
        longint v = longint'($signed(a));
        if (v >= 64'sd1073741824)  return {1'b1, 32'h7FFFFFFF};
        if (v <= -64'sd1073741824) return {1'b1, 32'h80000000};
        return {1'b0, a << 1};
    endfunction

    function automatic logic [32:0] m_ssat(longint v, int n);
        longint hi = (longint'(1) << n) - 1;
        longint lo = -(longint'(1) << n);
        if (v > hi) return {1'b1, hi[31:0]};
        if (v < lo) return {1'b1, lo[31:0]};
        return {1'b0, v[31:0]};
    endfunction

    function automatic logic [32:0] m_usat(longint v, int n);
        longint hi = (longint'(1) << n) - 1;
        if (v < 0)  return {1'b1, 32'h0};
        if (v > hi) return {1'b1, hi[31:0]};
        return {1'b0, v[31:0]};
    endfunction

    function automatic logic [32:0] m_dual(logic [31:0] a, int n, bit uns);
        logic [32:0] lo, hi;
        lo = uns ? m_usat(longint'($signed(a[15:0])), n) : m_ssat(longint'($signed(a[15:0])), n);
        hi = uns ? m_usat(longint'($signed(a[31:16])), n) : m_ssat(longint'($signed(a[31:16])), n);
        return {lo[32] | hi[32], hi[15:0], lo[15:0]};
    endfunction

    task automatic chk(string tag, logic [31:0] exp_res, logic exp_flag);
        checks++;
        if (result !== exp_res || sat_flag !== exp_flag) begin
            failures++;
            $display("FAIL %s: result=%h flag=%b expected result=%h flag=%b",
                     tag, result, sat_flag, exp_res, exp_flag);
        end
    endtask

    // One clock: drive at negedge, capture at posedge, return at next negedge.
    task automatic step(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [4:0] n,
                        logic v, logic c);
        op_sel = op; opnd_a = a; opnd_b = b; sat_width = n; in_valid = v; flag_clr = c;
        @(negedge clk);
    endtask

    // Clear the flag, then run one operation.
    task automatic run_op(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [4:0] n);
        step(4'd0, 32'h0, 32'h0, 5'd0, 1'b0, 1'b1);
        step(op, a, b, n, 1'b1, 1'b0);
    endtask

    task automatic try(string tag, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                       logic [4:0] n, logic [32:0] exp);
        run_op(op, a, b, n);
        chk(tag, exp[31:0], exp[32]);
    endtask

    task automatic t_reset();
        step(4'd0, 32'h0, 32'h0, 5'd0, 1'b1, 1'b0);
        chk("R1 reset state", 32'h0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_signed();
        try("R2 add no ovf", 4'd0, 32'd100, 32'hFFFFFFF6, 5'd0, m_signed(32'd100, 32'hFFFFFFF6, 0, 1));
        try("R2 add pos ovf", 4'd0, 32'h7FFFFFF0, 32'h20, 5'd0, m_signed(32'h7FFFFFF0, 32'h20, 0, 1));
        try("R2 add neg ovf", 4'd0, 32'h80000001, 32'hFFFFFFFE, 5'd0, m_signed(32'h80000001, 32'hFFFFFFFE, 0, 1));
        try("R3 sub no ovf", 4'd1, 32'd5, 32'd9, 5'd0, m_signed(32'd5, 32'd9, 1, 1));
        try("R3 sub pos ovf", 4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, m_signed(32'h7FFFFFFF, 32'hFFFFFFFF, 1, 1));
        try("R3 sub neg ovf", 4'd1, 32'h80000000, 32'd1, 5'd0, m_signed(32'h80000000, 32'd1, 1, 1));
        try("R4 flag add wraps", 4'd2, 32'h7FFFFFFF, 32'd1, 5'd0, m_signed(32'h7FFFFFFF, 32'd1, 0, 0));
        try("R4 flag add plain", 4'd2, 32'd7, 32'd8, 5'd0, m_signed(32'd7, 32'd8, 0, 0));
    endtask

    task automatic t_double();
        try("R5 dbl hi edge", 4'd3, 32'h40000000, 32'h0, 5'd0, m_dbl(32'h40000000));
        try("R5 dbl below hi", 4'd3, 32'h3FFFFFFF, 32'h0, 5'd0, m_dbl(32'h3FFFFFFF));
        try("R5 dbl lo edge", 4'd3, 32'hC0000000, 32'h0, 5'd0, m_dbl(32'hC0000000));
        try("R5 dbl above lo", 4'd3, 32'hC0000001, 32'h0, 5'd0, m_dbl(32'hC0000001));
    endtask

    task automatic t_unsigned();
        try("R6 uadd wrap", 4'd4, 32'hFFFFFFF0, 32'h20, 5'd0, m_uns(32'hFFFFFFF0, 32'h20, 0));
        try("R6 uadd plain", 4'd4, 32'hFFFFFFF0, 32'hF, 5'd0, m_uns(32'hFFFFFFF0, 32'hF, 0));
        try("R6 usub borrow", 4'd5, 32'd3, 32'd4, 5'd0, m_uns(32'd3, 32'd4, 1));
        try("R6 usub equal", 4'd5, 32'd4, 32'd4, 5'd0, m_uns(32'd4, 32'd4, 1));
    endtask

    task automatic t_width();
        try("R7 ssat hi", 4'd6, 32'd128, 32'h0, 5'd7, m_ssat(128, 7));
        try("R7 ssat at hi", 4'd6, 32'd127, 32'h0, 5'd7, m_ssat(127, 7));
        try("R7 ssat at lo", 4'd6, 32'hFFFFFF80, 32'h0, 5'd7, m_ssat(-128, 7));
        try("R7 ssat lo", 4'd6, 32'hFFFFFF7F, 32'h0, 5'd7, m_ssat(-129, 7));
        try("R7 ssat n0", 4'd6, 32'd1, 32'h0, 5'd0, m_ssat(1, 0));
        try("R8 usat neg", 4'd7, 32'hFFFFFFFF, 32'h0, 5'd8, m_usat(-1, 8));
        try("R8 usat hi", 4'd7, 32'd256, 32'h0, 5'd8, m_usat(256, 8));
        try("R8 usat at hi", 4'd7, 32'd255, 32'h0, 5'd8, m_usat(255, 8));
        try("R8 usat n31", 4'd7, 32'h7FFFFFFF, 32'h0, 5'd31, m_usat(64'sh7FFFFFFF, 31));
    endtask

    task automatic t_dual();
        try("R9 ssat16 both", 4'd8, 32'h8000_7FFF, 32'h0, 5'd4, m_dual(32'h8000_7FFF, 4, 0));
        try("R9 ssat16 none", 4'd8, 32'hFFF8_0007, 32'h0, 5'd3, m_dual(32'hFFF8_0007, 3, 0));
        try("R9 ssat16 wide n", 4'd8, 32'h8000_7FFF, 32'h0, 5'd20, m_dual(32'h8000_7FFF, 20, 0));
        try("R9 usat16 hi only", 4'd9, 32'h0100_0005, 32'h0, 5'd8, m_dual(32'h0100_0005, 8, 1));
        try("R9 usat16 neg lo", 4'd9, 32'h0003_FFFE, 32'h0, 5'd8, m_dual(32'h0003_FFFE, 8, 1));
    endtask

    task automatic t_hold_undef();
        run_op(4'd0, 32'h7FFFFFFF, 32'd1, 5'd0);
        step(4'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd0, 1'b0, 1'b0);
        step(4'd1, 32'h12345678, 32'h1, 5'd0, 1'b0, 1'b0);
        chk("R10 hold while invalid", 32'h7FFFFFFF, 1'b1);
        try("R10 undefined code", 4'd12, 32'h7FFFFFFF, 32'd1, 5'd0, 33'h0);
        run_op(4'd4, 32'd1, 32'd2, 5'd0);
        step(4'd0, 32'h7FFFFFFF, 32'd1, 5'd0, 1'b0, 1'b0);
        chk("R10 no flag without valid", 32'd3, 1'b0);
    endtask

    task automatic t_sticky();
        run_op(4'd5, 32'd0, 32'd1, 5'd0);
        step(4'd4, 32'd2, 32'd3, 5'd0, 1'b1, 1'b0);
        chk("R11 flag stays set", 32'd5, 1'b1);
        step(4'd4, 32'hFFFFFFFF, 32'd1, 5'd0, 1'b1, 1'b1);
        chk("R11 clear wins", 32'hFFFFFFFF, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_signed();
        t_double();
        t_unsigned();
        t_width();
        t_dual();
        t_hold_undef();
        t_sticky();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule